// File: doc/BRIEF.md
# Page-Register Address Mapper

This block widens a 16-bit processor address into a 21-bit physical address. The 64 KB logical space is cut into eight windows of 8 KB. Each window has its own 8-bit bank register. The three top bits of the logical address pick a register, and that register's bank number is placed above the 13-bit offset within the window. The translation path is purely combinational, so every bus access is mapped in the same cycle in which it is issued.

A processor core loads a bank register from its accumulator through a synchronous write port. A combinational read port returns any register so that the core can copy it back.

Reset gives only the highest window a known value, bank zero, so that boot code and the vector at the top of the logical space can be fetched. The other seven registers have no reset and stay undefined until software writes them.

Three decode flags come with each translated address:
- one marks the peripheral bank (all ones);
- one marks the work-RAM bank (0xF8);
- one marks the upper half of the physical space, which is reserved for external peripherals.

Top module: `bank_mapper`

## Requirements
- R1: physAddr[12:0] always equals cpuAddr[12:0].
- R2: physAddr[20:13] equals the bank register selected by cpuAddr[15:13], window 0 being 0x0000-0x1FFF and window 7 being 0xE000-0xFFFF.
- R3: While rst_n is low, and after it rises, register 7 holds 0x00 until it is written, so logical 0xFFFE translates to physical 0x001FFE. A later reset restores 0x00 to register 7 even after software has written it.
- R4: When mapWrEn is high at a rising clock edge, register mapWrIdx takes mapWrData. The new value is visible on the read port and in translation after that edge, and no other register changes.
- R5: With mapWrEn low, no register changes at any edge.
- R6: mapRdData shows register mapRdIdx combinationally. When a write to that register is pending in the same cycle, the old value is shown until the edge.
- R7: ioSel is high exactly when the translated bank is 0xFF.
- R8: ramSel is high exactly when the translated bank is 0xF8.
- R9: extSel is high exactly when the translated bank is 0x80 or above (bank bit 7 set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | Logical address of the current access |
| mapWrEn | input | 1 | Write strobe for the bank registers |
| mapWrIdx | input | 3 | Register selected for the write |
| mapWrData | input | 8 | Bank number to write |
| mapRdIdx | input | 3 | Register selected for read-back |
| mapRdData | output | 8 | Read-back value |
| physAddr | output | 21 | Translated physical address |
| ioSel | output | 1 | Translated bank is the peripheral bank |
| ramSel | output | 1 | Translated bank is the work-RAM bank |
| extSel | output | 1 | Translated bank lies in the upper physical half |

## Verification
The bench builds the block with its default parameters:
- the peripheral bank at 0xFF;
- the RAM bank at 0xF8;
- the boot bank at 0x00.

With these values, the directed cases reach the same physical targets that boot software uses: the reset vector, the RAM window and the peripheral window. The random phase writes every one of the eight registers with random banks and sweeps random addresses across all windows. It therefore covers every register index, both halves of the physical space, and writes that coincide with read-back of the same register.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int LOG_W      = 16;
  localparam int PAGE_SEL_W = 3;
  localparam int BANK_W     = 8;
  localparam int OFFSET_W   = LOG_W - PAGE_SEL_W;
  localparam int PHYS_W     = BANK_W + OFFSET_W;
  localparam int NUM_PAGES  = 1 << PAGE_SEL_W;

  typedef logic [BANK_W-1:0]     bank_t;
  typedef logic [PAGE_SEL_W-1:0] page_idx_t;

  typedef struct packed {
    logic [NUM_PAGES-1:0] wrStrobe;
    bank_t                wrData;
  } map_ctl_t;
endpackage

// File: rtl/bank_mapper_ctrl.sv
module bank_mapper_ctrl
  import bank_mapper_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mapWrEn,
  input  page_idx_t mapWrIdx,
  input  bank_t     mapWrData,
  output map_ctl_t  ctl
);
  logic [NUM_PAGES-1:0] strobeVec;

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_strobe
    assign strobeVec[i] = mapWrEn && (mapWrIdx == page_idx_t'(i));
  end

  always_comb begin
    ctl          = '0;
    ctl.wrStrobe = strobeVec;
    ctl.wrData   = mapWrData;
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl.wrStrobe)); // R4

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !mapWrEn |-> (ctl.wrStrobe == '0)); // R5

  AST_STROBE_HITS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    mapWrEn |-> ($countones(ctl.wrStrobe) == 1)); // R4
endmodule

// File: rtl/bank_mapper_datapath.sv
module bank_mapper_datapath
  import bank_mapper_pkg::*;
#(
  parameter bank_t BOOT_BANK = 8'h00,
  parameter bank_t IO_BANK   = 8'hFF,
  parameter bank_t RAM_BANK  = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  map_ctl_t          ctl,
  input  logic [LOG_W-1:0]  cpuAddr,
  input  page_idx_t         mapRdIdx,
  output bank_t             mapRdData,
  output logic [PHYS_W-1:0] physAddr,
  output logic              ioSel,
  output logic              ramSel,
  output logic              extSel
);
  localparam int TOP_PAGE = NUM_PAGES - 1;

  bank_t     bankReg [NUM_PAGES];
  page_idx_t curPage;
  bank_t     curBank;

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_reg
    if (i == TOP_PAGE) begin : g_boot
      // Only the top window is reset, so the boot code can be fetched.
      always_ff @(posedge clk) begin
        if (!rst_n)                bankReg[i] <= BOOT_BANK;
        else if (ctl.wrStrobe[i])  bankReg[i] <= ctl.wrData;
      end
    end else begin : g_plain
      // The other windows have no reset and are undefined until written.
      always_ff @(posedge clk) begin
        if (ctl.wrStrobe[i])       bankReg[i] <= ctl.wrData;
      end
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.wrStrobe[i] |=> $stable(bankReg[i])); // R5
  end

  assign curPage   = cpuAddr[LOG_W-1 -: PAGE_SEL_W];
  assign curBank   = bankReg[curPage];
  assign mapRdData = bankReg[mapRdIdx];
  assign physAddr  = {curBank, cpuAddr[OFFSET_W-1:0]};
  assign ioSel     = (curBank == IO_BANK);
  assign ramSel    = (curBank == RAM_BANK);
  assign extSel    = curBank[BANK_W-1];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.wrStrobe != '0) |=> (bankReg[$past(mapRdIdx)] == bankReg[$past(mapRdIdx)]) &&
    $past(ctl.wrStrobe[TOP_PAGE]) |-> (bankReg[TOP_PAGE] == $past(ctl.wrData))); // R4

  AST_BOOT_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !ctl.wrStrobe[TOP_PAGE]) |=> (bankReg[TOP_PAGE] == BOOT_BANK)); // R3
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter logic [7:0] BOOT_BANK = 8'h00,
  parameter logic [7:0] IO_BANK   = 8'hFF,
  parameter logic [7:0] RAM_BANK  = 8'hF8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cpuAddr,
  input  logic        mapWrEn,
  input  logic [2:0]  mapWrIdx,
  input  logic [7:0]  mapWrData,
  input  logic [2:0]  mapRdIdx,
  output logic [7:0]  mapRdData,
  output logic [20:0] physAddr,
  output logic        ioSel,
  output logic        ramSel,
  output logic        extSel
);
  map_ctl_t ctl;

  bank_mapper_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mapWrEn   (mapWrEn),
    .mapWrIdx  (mapWrIdx),
    .mapWrData (mapWrData),
    .ctl       (ctl)
  );

  bank_mapper_datapath #(
    .BOOT_BANK (BOOT_BANK),
    .IO_BANK   (IO_BANK),
    .RAM_BANK  (RAM_BANK)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .cpuAddr   (cpuAddr),
    .mapRdIdx  (mapRdIdx),
    .mapRdData (mapRdData),
    .physAddr  (physAddr),
    .ioSel     (ioSel),
    .ramSel    (ramSel),
    .extSel    (extSel)
  );

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    physAddr[12:0] == cpuAddr[12:0]); // R1

  AST_IO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ioSel |-> (physAddr[20:13] == IO_BANK)); // R7

  AST_RAM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ramSel |-> (physAddr[20:13] == RAM_BANK)); // R8

  AST_EXT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    extSel == physAddr[20]); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ioSel && ramSel)); // R7
endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic        mapWrEn = 1'b0;
  logic [2:0]  mapWrIdx = '0;
  logic [7:0]  mapWrData = '0;
  logic [2:0]  mapRdIdx = '0;
  logic [7:0]  mapRdData;
  logic [20:0] physAddr;
  logic        ioSel, ramSel, extSel;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model [8];
  bit done = 0;

  always #2.5 clk = ~clk;

  bank_mapper u_dut (
    .clk(clk), .rst_n(rst_n), .cpuAddr(cpuAddr), .mapWrEn(mapWrEn),
    .mapWrIdx(mapWrIdx), .mapWrData(mapWrData), .mapRdIdx(mapRdIdx),
    .mapRdData(mapRdData), .physAddr(physAddr), .ioSel(ioSel),
    .ramSel(ramSel), .extSel(extSel)
  );

  function automatic logic [20:0] expPhys(input logic [15:0] a);
    return {model[a[15:13]], a[12:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Apply an address, then compare all translation outputs against the model.
  task automatic probe(input logic [15:0] a);
    logic [7:0] b;
    cpuAddr = a;
    #1;
    b = model[a[15:13]];
    check("R1", 32'(physAddr[12:0]), 32'(a[12:0]));
    check("R2", 32'(physAddr[20:13]), 32'(b));
    check("R7", 32'(ioSel), 32'(b == 8'hFF));
    check("R8", 32'(ramSel), 32'(b == 8'hF8));
    check("R9", 32'(extSel), 32'(b[7]));
  endtask

  task automatic writeReg(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    mapWrEn = 1'b1; mapWrIdx = idx; mapWrData = d;
    @(negedge clk);
    mapWrEn = 1'b0;
    model[idx] = d;
  endtask

  task automatic checkAllRegs(input string req);
    for (int i = 0; i < 8; i++) begin
      mapRdIdx = 3'(i);
      #1;
      check(req, 32'(mapRdData), 32'(model[i]));
    end
  endtask

  initial begin
    #(5 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seedInit;
    seedInit = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    // R3: top window is bank 0 while held in reset
    mapRdIdx = 3'd7;
    #1;
    check("R3", 32'(mapRdData), 32'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model[7] = 8'h00;
    mapRdIdx = 3'd7;
    #1;
    check("R3", 32'(mapRdData), 32'h00);
    cpuAddr = 16'hFFFE;
    #1;
    check("R3", 32'(physAddr), 32'h001FFE);

    // Directed boot-style mapping: peripheral, RAM, cartridge windows
    writeReg(3'd0, 8'hFF);
    writeReg(3'd1, 8'hF8);
    writeReg(3'd4, 8'h04);
    for (int i = 0; i < 8; i++) if (i != 0 && i != 1 && i != 4 && i != 7) writeReg(3'(i), 8'(i + 8'h10));
    probe(16'h0123);
    check("R7", 32'(physAddr), 32'h1FE123);
    probe(16'h2000);
    check("R8", 32'(physAddr), 32'h1F0000);
    probe(16'hD123 & 16'h1FFF | 16'h8000);
    check("R2", 32'(physAddr), 32'h009123);
    probe(16'hFFFE);
    checkAllRegs("R4");

    // R6: read shows old value while a write to the same register is pending
    @(negedge clk);
    mapRdIdx = 3'd2; mapWrEn = 1'b1; mapWrIdx = 3'd2; mapWrData = 8'h55;
    #1;
    check("R6", 32'(mapRdData), 32'(model[2]));
    @(negedge clk);
    mapWrEn = 1'b0;
    model[2] = 8'h55;
    #1;
    check("R6", 32'(mapRdData), 32'h55);

    // R5: idle cycles with changing write data do not disturb registers
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      mapWrIdx = 3'($urandom); mapWrData = 8'($urandom);
    end
    checkAllRegs("R5");

    // R4: single write leaves the others alone; boundary banks 0x7F/0x80
    writeReg(3'd3, 8'h7F);
    probe(16'h6000);
    writeReg(3'd3, 8'h80);
    probe(16'h7FFF);
    checkAllRegs("R4");

    // Random mixing of writes and translations
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 3) == 0) writeReg(3'($urandom), 8'($urandom));
      else @(negedge clk);
      probe(16'($urandom));
      mapRdIdx = 3'($urandom);
      #1;
      check("R6", 32'(mapRdData), 32'(model[mapRdIdx]));
    end

    // R3: a later reset restores the top window to bank 0
    writeReg(3'd7, 8'hA5);
    probe(16'hE000);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    model[7] = 8'h00;
    @(negedge clk);
    cpuAddr = 16'hFFFE;
    #1;
    check("R3", 32'(physAddr), 32'h001FFE);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule